// File: doc/BRIEF.md
# Counter Event Interrupt Controller

This block sits beside a counting channel and turns five kinds of channel event into one interrupt request. The events are the opening edge of the hardware gate, its closing edge, a comparator match, counting past the upper limit and counting past the lower limit. Each event has its own enable input. Gate edges are also qualified by the software gate: they count only while that gate is open.

The hardware gate arrives as a level that is already synchronized. The block finds its edges against a registered copy. The comparator, overflow and underflow events arrive as single-cycle strobes from the counter core. A qualified event sets its own sticky bit in a five-bit cause vector, and the request line is high while any cause bit is set. Software acknowledges by pulsing a write-one-to-clear mask. An event that arrives while its source is disabled is lost and is not kept for later.

Top module: `cnt_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every cause bit and drops the request. Strobes or gate edges presented during reset leave no trace afterwards.
- R2: A 0-to-1 change of the gate level sets cause bit 0 at the next clock edge, provided enable bit 0 is set and the software gate is open.
- R3: A 1-to-0 change of the gate level sets cause bit 1 at the next clock edge, provided enable bit 1 is set and the software gate is open.
- R4: A gate edge seen while the software gate is closed sets neither cause bit 0 nor cause bit 1.
- R5: A strobe sets its cause bit at the next clock edge when the matching enable bit is set. The comparator strobe maps to bit 2, the overflow strobe to bit 3 and the underflow strobe to bit 4.
- R6: An event whose enable bit is clear is dropped. Setting the enable bit later does not set the cause bit.
- R7: A cause bit stays set until it is acknowledged. A gate level held steady after an edge produces no further event, so the bit stays clear once it is acknowledged.
- R8: A one in bit i of the acknowledge mask clears cause bit i at the next clock edge. Cause bits whose mask bit is zero are unchanged.
- R9: If a qualified event and the acknowledge of the same bit fall in one cycle, the bit is set after that edge.
- R10: The request output is high exactly when at least one cause bit is set.
- R11: A gate level that is already high when reset is released does not count as an opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_lvl | input | 1 | Synchronized hardware gate level |
| sw_gate_open | input | 1 | Software gate is open |
| cmp_hit | input | 1 | Comparator match strobe, one cycle |
| ovf_hit | input | 1 | Upper-limit overflow strobe, one cycle |
| unf_hit | input | 1 | Lower-limit underflow strobe, one cycle |
| src_en | input | 5 | Per-source enable (bit 0 open, 1 close, 2 compare, 3 overflow, 4 underflow) |
| ack_clr | input | 5 | Write-one-to-clear acknowledge mask |
| irq_req | output | 1 | Interrupt request |
| cause | output | 5 | Sticky cause bits, same bit order as src_en |

## Verification
Two functions can meet in one cycle: a new event that sets a cause bit, and a software acknowledge that clears the same bit. The bench provokes this by driving a strobe, or a gate edge, in the same cycle as the acknowledge bit for that source. It also acknowledges a neighbouring bit in that cycle. The check passes if the colliding bit is still set after the edge and the neighbour is cleared. A bound property also checks the overflow collision on every cycle.

// File: rtl/cnt_irq_pkg.sv
// Package: shared constants for the counter event interrupt controller.
// Assumes the five sources use a fixed bit order that software decodes.
package cnt_irq_pkg;
    localparam int NUM_SRC = 5;

    // Bit position of each source in the enable, cause and acknowledge vectors
    typedef enum int {
        SRC_GATE_OPEN  = 0,
        SRC_GATE_CLOSE = 1,
        SRC_CMP        = 2,
        SRC_OVF        = 3,
        SRC_UNF        = 4
    } src_idx_e;

    // Sources that also need the software gate to be open
    localparam logic [NUM_SRC-1:0] GATE_SRC_MASK =
        (NUM_SRC'(1) << SRC_GATE_OPEN) | (NUM_SRC'(1) << SRC_GATE_CLOSE);
endpackage

// File: rtl/cirq_gate_edge.sv
// Module: cirq_gate_edge
// Finds rising and falling edges of an already synchronized gate level.
// Each edge is compared against a registered copy, so one edge gives a
// one-cycle pulse. After reset the first sampled level only primes the
// copy and produces no edge.
module cirq_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;
    logic primed;

    // Keep the previous gate level and mark when it is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            primed <= 1'b0;
        end else begin
            lvl_q  <= lvl;
            primed <= 1'b1;
        end
    end

    // Edge pulses are valid only once the copy holds a real sample
    always_comb begin
        rise = primed &  lvl & ~lvl_q;
        fall = primed & ~lvl &  lvl_q;
    end
endmodule

// File: rtl/cirq_qualify.sv
// Module: cirq_qualify
// Gates each raw event with its enable bit. The sources named in
// GATE_MASK also need the software gate to be open. Purely
// combinational, with nothing held pending.
module cirq_qualify #(
    parameter int               WIDTH     = 5,
    parameter logic [WIDTH-1:0] GATE_MASK = '0
) (
    input  logic [WIDTH-1:0] raw_evt,
    input  logic [WIDTH-1:0] en,
    input  logic             sw_open,
    output logic [WIDTH-1:0] qual_evt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        if (GATE_MASK[i]) begin : g_gated
            // Gate edge source: enable and software gate both needed
            always_comb qual_evt[i] = raw_evt[i] & en[i] & sw_open;
        end else begin : g_plain
            // Counter source: the enable alone decides
            always_comb qual_evt[i] = raw_evt[i] & en[i];
        end
    end
endmodule

// File: rtl/cirq_cause_reg.sv
// Module: cirq_cause_reg
// Sticky cause bits with a write-one-to-clear acknowledge. A set and a
// clear of the same bit in the same cycle leave the bit set.
module cirq_cause_reg #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_evt,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] bits
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One sticky bit: a set wins over a clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[i] <= 1'b0;
            else if (set_evt[i])
                bits[i] <= 1'b1;
            else if (clr_mask[i])
                bits[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cnt_irq_ctrl.sv
// Module: cnt_irq_ctrl (top)
// Interrupt controller for one counting channel. It detects gate edges,
// qualifies all five sources, latches causes and drives the request.
// Assumes the gate level is synchronized and the strobes are single-cycle.
module cnt_irq_ctrl
    import cnt_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_lvl,
    input  logic               sw_gate_open,
    input  logic               cmp_hit,
    input  logic               ovf_hit,
    input  logic               unf_hit,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic               irq_req,
    output logic [NUM_SRC-1:0] cause
);
    logic               gate_rise;
    logic               gate_fall;
    logic [NUM_SRC-1:0] raw_evt;
    logic [NUM_SRC-1:0] qual_evt;

    cirq_gate_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (gate_lvl),
        .rise (gate_rise),
        .fall (gate_fall)
    );

    // Collect the raw events in the bit order of the cause vector
    always_comb begin
        raw_evt                 = '0;
        raw_evt[SRC_GATE_OPEN]  = gate_rise;
        raw_evt[SRC_GATE_CLOSE] = gate_fall;
        raw_evt[SRC_CMP]        = cmp_hit;
        raw_evt[SRC_OVF]        = ovf_hit;
        raw_evt[SRC_UNF]        = unf_hit;
    end

    cirq_qualify #(
        .WIDTH    (NUM_SRC),
        .GATE_MASK(GATE_SRC_MASK)
    ) u_qual (
        .raw_evt (raw_evt),
        .en      (src_en),
        .sw_open (sw_gate_open),
        .qual_evt(qual_evt)
    );

    cirq_cause_reg #(
        .WIDTH(NUM_SRC)
    ) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (qual_evt),
        .clr_mask(ack_clr),
        .bits    (cause)
    );

    // The request is high while any cause bit is set
    always_comb irq_req = |cause;
endmodule

// File: rtl/cnt_irq_ctrl_chk.sv
// Module: cnt_irq_ctrl_chk
// Property checker bound to cnt_irq_ctrl. It observes only the top ports.
module cnt_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_gate_open,
    input logic       cmp_hit,
    input logic       ovf_hit,
    input logic       unf_hit,
    input logic [4:0] src_en,
    input logic [4:0] ack_clr,
    input logic [4:0] cause
);
    // R5: an enabled comparator strobe sets cause bit 2
    a_r5_cmp_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en[2] && cmp_hit) |=> cause[2]);

    // R6: a clear bit stays clear while its enable is off
    a_r6_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en[2] && !cause[2]) |=> !cause[2]);

    // R4: a closed software gate keeps the opening bit clear
    a_r4_sw_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_gate_open && !cause[0]) |=> !cause[0]);

    // R7: a set bit that is not acknowledged stays set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[3] && !ack_clr[3]) |=> cause[3]);

    // R8: an acknowledge without an event clears the bit
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[4] && !(src_en[4] && unf_hit)) |=> !cause[4]);

    // R9: an event beats an acknowledge in the same cycle
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en[3] && ovf_hit && ack_clr[3]) |=> cause[3]);
endmodule

bind cnt_irq_ctrl cnt_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_gate_open(sw_gate_open),
    .cmp_hit     (cmp_hit),
    .ovf_hit     (ovf_hit),
    .unf_hit     (unf_hit),
    .src_en      (src_en),
    .ack_clr     (ack_clr),
    .cause       (cause)
);

// File: tb/cnt_irq_ctrl_test.sv
// Directed bench for cnt_irq_ctrl. Each task drives one scenario and checks it.
module cnt_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_lvl = 1'b0;
    logic       sw_gate_open = 1'b0;
    logic       cmp_hit = 1'b0;
    logic       ovf_hit = 1'b0;
    logic       unf_hit = 1'b0;
    logic [4:0] src_en = '0;
    logic [4:0] ack_clr = '0;
    logic       irq_req;
    logic [4:0] cause;
    int         n_chk = 0;
    int         n_err = 0;

    always #2 clk = ~clk;  // 250 MHz

    cnt_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .gate_lvl(gate_lvl), .sw_gate_open(sw_gate_open),
        .cmp_hit(cmp_hit), .ovf_hit(ovf_hit), .unf_hit(unf_hit),
        .src_en(src_en), .ack_clr(ack_clr), .irq_req(irq_req), .cause(cause)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Wait for the next rising edge, then sample 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drv();
        @(negedge clk);
    endtask

    // Acknowledge everything and clear all strobes
    task automatic flush();
        drv(); cmp_hit = 0; ovf_hit = 0; unf_hit = 0; ack_clr = 5'h1f;
        tick();
        drv(); ack_clr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; src_en = 5'h1f; sw_gate_open = 1; cmp_hit = 1; ovf_hit = 1; unf_hit = 1;
        tick(); tick();
        chk("R1 cause in reset", cause, 5'b0);
        chk("R10 irq in reset", {4'b0, irq_req}, 5'b0);
        drv(); cmp_hit = 0; ovf_hit = 0; unf_hit = 0; rst_n = 1;
        tick();
        chk("R1 no trace after reset", cause, 5'b0);
    endtask

    task automatic t_gate_high_at_reset();
        drv(); rst_n = 0; gate_lvl = 1; src_en = 5'h1f; sw_gate_open = 1;
        tick();
        drv(); rst_n = 1;
        tick(); tick();
        chk("R11 high gate at release", cause, 5'b0);
        drv(); gate_lvl = 0;
        tick();
        chk("R3 close edge after release", cause, 5'b00010);
        flush();
    endtask

    task automatic t_gate_edges();
        drv(); src_en = 5'b00011; sw_gate_open = 1; gate_lvl = 1;
        tick();
        chk("R2 open edge", cause, 5'b00001);
        chk("R10 irq high", {4'b0, irq_req}, 5'b1);
        drv(); ack_clr = 5'b00001;
        tick();
        drv(); ack_clr = 0;
        tick(); tick();
        chk("R7 held level no re-event", cause, 5'b0);
        chk("R10 irq low", {4'b0, irq_req}, 5'b0);
        drv(); gate_lvl = 0;
        tick();
        chk("R3 close edge", cause, 5'b00010);
        flush();
    endtask

    task automatic t_sw_gate_closed();
        drv(); src_en = 5'b00011; sw_gate_open = 0; gate_lvl = 1;
        tick();
        drv(); gate_lvl = 0;
        tick(); tick();
        chk("R4 edges with sw gate closed", cause, 5'b0);
        drv(); sw_gate_open = 1;
        tick();
        chk("R4 opening sw gate later", cause, 5'b0);
    endtask

    task automatic t_strobes();
        drv(); src_en = 5'b11100; cmp_hit = 1;
        tick();
        chk("R5 compare bit 2", cause, 5'b00100);
        drv(); cmp_hit = 0; ovf_hit = 1;
        tick();
        chk("R5 overflow bit 3", cause, 5'b01100);
        drv(); ovf_hit = 0; unf_hit = 1;
        tick();
        chk("R5 underflow bit 4", cause, 5'b11100);
        drv(); unf_hit = 0;
        tick(); tick();
        chk("R7 bits stay set", cause, 5'b11100);
        flush();
    endtask

    task automatic t_disabled();
        drv(); src_en = 5'b0; cmp_hit = 1; ovf_hit = 1; unf_hit = 1;
        tick();
        chk("R6 disabled strobes dropped", cause, 5'b0);
        drv(); cmp_hit = 0; ovf_hit = 0; unf_hit = 0; src_en = 5'h1f;
        tick(); tick();
        chk("R6 no pending after enable", cause, 5'b0);
    endtask

    task automatic t_ack_select();
        drv(); src_en = 5'b11100; cmp_hit = 1; ovf_hit = 1; unf_hit = 1;
        tick();
        drv(); cmp_hit = 0; ovf_hit = 0; unf_hit = 0; ack_clr = 5'b01000;
        tick();
        chk("R8 selective clear", cause, 5'b10100);
        drv(); ack_clr = 0;
        flush();
    endtask

    task automatic t_collision();
        drv(); src_en = 5'b11100; cmp_hit = 1; unf_hit = 1;
        tick();
        drv(); cmp_hit = 0; unf_hit = 0; ovf_hit = 1; ack_clr = 5'b11000;
        tick();
        chk("R9 event beats ack, neighbour cleared", cause, 5'b01100);
        drv(); ovf_hit = 0; ack_clr = 0;
        flush();
        drv(); src_en = 5'b00001; sw_gate_open = 1; gate_lvl = 0;
        tick();
        drv(); gate_lvl = 1; ack_clr = 5'b00001;
        tick();
        chk("R9 gate edge beats ack", cause, 5'b00001);
        drv(); ack_clr = 0;
        flush();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_gate_high_at_reset();
                t_gate_edges();
                t_sw_gate_closed();
                t_strobes();
                t_disabled();
                t_ack_select();
                t_collision();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule